// File: doc/BRIEF.md
# Gate Driver Fault Protection Controller

This block is the clocked digital core that sits between a controller and the driver stage of an isolated power switch. It accepts a complementary pair of gate commands, debounces them, and issues a single gate-on command only when the pair asks for it, the output-side supply is good and no fault is held. After each turn-on it ignores the desaturation comparator for a fixed window while the switch settles. It then requires the comparator flag to persist before treating it as a real overload.

A qualified overload switches the gate off on the next clock and latches a trip. The trip blocks the command inputs. After a further delay, which stands for the time a fault takes to cross the isolation barrier, the active-low fault output drops. The trip is released only by a long low pulse on the clear input, or when the input-side supply is lost. A ready output reports whether both supplies are good. All timing constants are parameters counted in clock cycles.

Top module: `gate_fault_ctrl`

## Requirements
- R1: `gate_on` is 1 only when the filtered `cmd_pos` is 1, the filtered `cmd_neg` is 0, `out_supply_ok` is 1 and no trip is latched. Every other combination gives 0.
- R2: A command input takes a new filtered level only after the raw input has differed from the filtered level on GLITCH_CYC consecutive clock edges. A shorter pulse leaves `gate_on` unchanged.
- R3: For the first BLANK_CYC clock edges of every period in which `gate_on` is 1, `desat_flag` is ignored.
- R4: Once blanking has ended, a trip latches on the DESAT_CYC-th consecutive edge that sees `desat_flag` at 1 while the gate is on, and `gate_on` is 0 from that edge. A shorter high run of `desat_flag` has no effect.
- R5: `fault_n` goes to 0 exactly FAULT_DLY_CYC edges after the trip edge. While the trip is held, `fault_n` stays 0 and `gate_on` stays 0 whatever the command inputs do.
- R6: The trip clears on the CLR_CYC-th consecutive edge that sees `clr_n` at 0. `fault_n` then returns to 1 and `gate_on` follows the filtered commands again. A low pulse shorter than CLR_CYC edges clears nothing.
- R7: A clear input held low clears the trip only once. A new qualified fault that occurs while it is still held low latches the trip again, and the trip stays held.
- R8: `ready` is 1 exactly when `in_supply_ok` and `out_supply_ok` are both 1.
- R9: `gate_on` is 0 in any cycle in which `out_supply_ok` is 0.
- R10: An edge that sees `in_supply_ok` at 0 clears the trip. It also returns the command filters to their idle levels (`cmd_pos` 0, `cmd_neg` 1) and resets every counter. After supply returns, turn-on again needs GLITCH_CYC edges.
- R11: While `rst_n` is 0, `gate_on` is 0 and `fault_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| cmd_pos | input | 1 | Non-inverting gate command |
| cmd_neg | input | 1 | Inverting gate command |
| clr_n | input | 1 | Active-low fault clear request |
| desat_flag | input | 1 | Desaturation comparator result, 1 = overload |
| in_supply_ok | input | 1 | Input-side supply good |
| out_supply_ok | input | 1 | Output-side supply good |
| gate_on | output | 1 | Gate-on command to the output stage |
| ready | output | 1 | Both supplies good |
| fault_n | output | 1 | Latched fault, active low |

## Verification
The bench aims at edge-exact boundaries where an off-by-one would be visible:
- A command pulse one edge short of the filter length must not reach the gate. A filter one edge too short would switch on early.
- A desaturation flag held from the moment of turn-on must trip on exactly the edge where blanking plus qualification ends. A blanking counter that failed to restart on each turn-on would trip in the first cycles.
- The fault output must drop exactly FAULT_DLY_CYC edges after the trip.
- A clear pulse one edge too short must leave the trip set.
- A clear held low across a second fault must not erase that fault. A design with a level-sensitive clear would let the gate switch again.
- Loss of the input-side supply must return the filters to idle, so turn-on afterwards costs a full filter time.

// File: rtl/gate_fault_ctrl.sv
module gate_fault_ctrl #(
  parameter int GLITCH_CYC    = 4,
  parameter int BLANK_CYC     = 50,
  parameter int DESAT_CYC     = 41,
  parameter int CLR_CYC       = 75,
  parameter int FAULT_DLY_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_pos,
  input  logic cmd_neg,
  input  logic clr_n,
  input  logic desat_flag,
  input  logic in_supply_ok,
  input  logic out_supply_ok,
  output logic gate_on,
  output logic ready,
  output logic fault_n
);

  localparam int GW = $clog2(GLITCH_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int DW = $clog2(DESAT_CYC + 1);
  localparam int CW = $clog2(CLR_CYC + 1);
  localparam int FW = $clog2(FAULT_DLY_CYC + 1);
  localparam logic [GW-1:0] G_LAST = GW'(GLITCH_CYC - 1);
  localparam logic [BW-1:0] B_END  = BW'(BLANK_CYC);
  localparam logic [DW-1:0] D_LAST = DW'(DESAT_CYC - 1);
  localparam logic [CW-1:0] C_LAST = CW'(CLR_CYC - 1);
  localparam logic [CW-1:0] C_END  = CW'(CLR_CYC);
  localparam logic [FW-1:0] F_END  = FW'(FAULT_DLY_CYC);
  localparam logic [1:0]    IDLE   = 2'b10;

  logic [1:0]    raw_cmd, cmd_f;
  logic [BW-1:0] blank_cnt;
  logic [DW-1:0] desat_cnt;
  logic [CW-1:0] clr_cnt;
  logic [FW-1:0] dly_cnt;
  logic          tripped;
  logic          armed, trip_fire, clr_fire;

  assign raw_cmd = {cmd_neg, cmd_pos};

  genvar i;
  for (i = 0; i < 2; i++) begin : g_flt
    logic          q;
    logic [GW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q   <= IDLE[i];
        cnt <= '0;
      end else if (!in_supply_ok) begin
        q   <= IDLE[i];
        cnt <= '0;
      end else if (raw_cmd[i] == q) begin
        cnt <= '0;
      end else if (cnt == G_LAST) begin
        q   <= raw_cmd[i];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
    assign cmd_f[i] = q;
  end

  assign gate_on   = cmd_f[0] & ~cmd_f[1] & out_supply_ok & ~tripped;
  assign ready     = in_supply_ok & out_supply_ok;
  assign armed     = gate_on && (blank_cnt == B_END);
  assign trip_fire = armed && desat_flag && (desat_cnt == D_LAST);
  assign clr_fire  = !clr_n && (clr_cnt == C_LAST);
  assign fault_n   = !(tripped && (dly_cnt == F_END));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_cnt <= '0;
      desat_cnt <= '0;
      clr_cnt   <= '0;
      dly_cnt   <= '0;
      tripped   <= 1'b0;
    end else if (!in_supply_ok) begin
      blank_cnt <= '0;
      desat_cnt <= '0;
      clr_cnt   <= '0;
      dly_cnt   <= '0;
      tripped   <= 1'b0;
    end else begin
      if (!gate_on)              blank_cnt <= '0;
      else if (blank_cnt != B_END) blank_cnt <= blank_cnt + 1'b1;

      if (armed && desat_flag && !trip_fire) desat_cnt <= desat_cnt + 1'b1;
      else                                   desat_cnt <= '0;

      if (clr_n)               clr_cnt <= '0;
      else if (clr_cnt != C_END) clr_cnt <= clr_cnt + 1'b1;

      if (!tripped)            dly_cnt <= '0;
      else if (dly_cnt != F_END) dly_cnt <= dly_cnt + 1'b1;

      if (trip_fire)     tripped <= 1'b1;
      else if (clr_fire) tripped <= 1'b0;
    end
  end

  // R5
  fault_blocks_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> !gate_on);

  // R9
  out_supply_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_supply_ok |-> !gate_on);

  // R4
  trip_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripped) |-> $past(gate_on && desat_flag));

  // R6
  fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> ($past(!clr_n) || $past(!in_supply_ok)));

  // R10
  supply_loss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_supply_ok |=> fault_n);

  // R2
  cmd_filter_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_f[0]) |-> ($past(cmd_pos) == cmd_f[0] || $past(!in_supply_ok)));

endmodule

// File: tb/tb_gate_fault_ctrl.sv
module tb_gate_fault_ctrl;
  localparam int G = 4, BL = 50, DS = 41, CL = 75, FD = 250;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_pos, cmd_neg, clr_n, desat_flag, in_supply_ok, out_supply_ok;
  logic gate_on, ready, fault_n;

  always #4 clk = ~clk;

  gate_fault_ctrl #(.GLITCH_CYC(G), .BLANK_CYC(BL), .DESAT_CYC(DS),
                    .CLR_CYC(CL), .FAULT_DLY_CYC(FD)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_pos(cmd_pos), .cmd_neg(cmd_neg),
    .clr_n(clr_n), .desat_flag(desat_flag), .in_supply_ok(in_supply_ok),
    .out_supply_ok(out_supply_ok), .gate_on(gate_on), .ready(ready),
    .fault_n(fault_n));

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_pf, m_nf, m_prun, m_nrun, m_on, m_ds, m_clow, m_age, m_trip;

  task automatic model_idle();
    m_pf = 0; m_nf = 1; m_prun = 0; m_nrun = 0; m_on = 0;
    m_ds = 0; m_clow = 0; m_age = 0; m_trip = 0;
  endtask

  function automatic bit m_gate();
    return (m_pf == 1) && (m_nf == 0) && out_supply_ok && (m_trip == 0);
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit g, armed, fire, cfire;
    if (!in_supply_ok) begin
      model_idle();
      return;
    end
    g     = m_gate();
    armed = g && (m_on >= BL);
    fire  = armed && desat_flag && (m_ds + 1 >= DS);
    cfire = !clr_n && (m_clow + 1 == CL);
    if (cmd_pos != m_pf) begin
      m_prun++;
      if (m_prun >= G) begin m_pf = cmd_pos; m_prun = 0; end
    end else m_prun = 0;
    if (cmd_neg != m_nf) begin
      m_nrun++;
      if (m_nrun >= G) begin m_nf = cmd_neg; m_nrun = 0; end
    end else m_nrun = 0;
    m_on  = g ? m_on + 1 : 0;
    m_ds  = (armed && desat_flag && !fire) ? m_ds + 1 : 0;
    m_clow = clr_n ? 0 : m_clow + 1;
    m_age = m_trip ? m_age + 1 : 0;
    if (fire) m_trip = 1;
    else if (cfire) m_trip = 0;
  endtask

  task automatic step(input bit p, input bit n, input bit c, input bit d,
                      input bit i, input bit o, input int cnt, input string req);
    for (int k = 0; k < cnt; k++) begin
      @(negedge clk);
      cmd_pos = p; cmd_neg = n; clr_n = c; desat_flag = d;
      in_supply_ok = i; out_supply_ok = o;
      #1;
      chk(req, "gate_on", gate_on, m_gate());
      chk(req, "ready", ready, in_supply_ok && out_supply_ok);
      chk(req, "fault_n", fault_n, !((m_trip != 0) && (m_age >= FD)));
      model_edge();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    bit rp, rn, rc, ri, ro;
    rst_n = 0; cmd_pos = 1; cmd_neg = 0; clr_n = 1; desat_flag = 0;
    in_supply_ok = 1; out_supply_ok = 1;
    model_idle();
    repeat (3) @(negedge clk);
    #1;
    chk("R11", "gate_on in reset", gate_on, 1'b0);
    chk("R11", "fault_n in reset", fault_n, 1'b1);
    @(negedge clk);
    cmd_pos = 0; cmd_neg = 1; rst_n = 1;

    // R2 / R1: turn-on after exactly G edges
    step(1, 0, 1, 0, 1, 1, 4, "R2");
    chk("R2", "gate still off after G-1 edges", gate_on, 1'b0);
    step(1, 0, 1, 0, 1, 1, 1, "R1");
    chk("R1", "gate on after G edges", gate_on, 1'b1);
    step(1, 0, 1, 0, 1, 1, 10, "R1");
    // R2: short low pulse on cmd_pos is rejected
    step(0, 0, 1, 0, 1, 1, 3, "R2");
    step(1, 0, 1, 0, 1, 1, 1, "R2");
    chk("R2", "short pulse ignored", gate_on, 1'b1);
    step(1, 0, 1, 0, 1, 1, 5, "R2");
    // R1: other command combinations
    step(1, 1, 1, 0, 1, 1, 8, "R1");
    chk("R1", "pos=1 neg=1 off", gate_on, 1'b0);
    step(0, 0, 1, 0, 1, 1, 8, "R1");
    chk("R1", "pos=0 neg=0 off", gate_on, 1'b0);
    step(0, 1, 1, 0, 1, 1, 8, "R1");
    chk("R1", "pos=0 neg=1 off", gate_on, 1'b0);
    // R8 / R9
    step(1, 0, 1, 0, 1, 1, 8, "R1");
    step(1, 0, 1, 0, 1, 0, 1, "R9");
    chk("R9", "gate off without output supply", gate_on, 1'b0);
    chk("R8", "ready low on output supply", ready, 1'b0);
    step(1, 0, 1, 0, 1, 0, 5, "R9");
    step(1, 0, 1, 0, 1, 1, 1, "R8");
    chk("R8", "ready back high", ready, 1'b1);
    // R4: short desat run after blanking is harmless
    step(1, 0, 1, 0, 1, 1, 60, "R3");
    step(1, 0, 1, 1, 1, 1, DS - 1, "R4");
    step(1, 0, 1, 0, 1, 1, 2, "R4");
    chk("R4", "short desat run ignored", gate_on, 1'b1);
    // R3 / R4: desat held from fresh turn-on
    step(0, 1, 1, 0, 1, 1, 10, "R1");
    step(1, 0, 1, 1, 1, 1, 95, "R3");
    chk("R3", "gate on through blanking and filter", gate_on, 1'b1);
    step(1, 0, 1, 1, 1, 1, 1, "R4");
    chk("R4", "gate off on trip edge", gate_on, 1'b0);
    // R5: fault output delay
    step(1, 0, 1, 0, 1, 1, FD - 1, "R5");
    chk("R5", "fault_n high before delay", fault_n, 1'b1);
    step(1, 0, 1, 0, 1, 1, 1, "R5");
    chk("R5", "fault_n low at delay", fault_n, 1'b0);
    step(0, 1, 1, 0, 1, 1, 20, "R5");
    step(1, 0, 1, 0, 1, 1, 20, "R5");
    chk("R5", "command blocked while tripped", gate_on, 1'b0);
    chk("R5", "fault held", fault_n, 1'b0);
    // R6: short clear ignored, full clear works
    step(1, 0, 0, 0, 1, 1, CL - 1, "R6");
    step(1, 0, 1, 0, 1, 1, 5, "R6");
    chk("R6", "short clear ignored", fault_n, 1'b0);
    step(1, 0, 0, 0, 1, 1, CL, "R6");
    chk("R6", "fault still low before clear edge", fault_n, 1'b0);
    step(1, 0, 0, 0, 1, 1, 1, "R6");
    chk("R6", "fault released", fault_n, 1'b1);
    chk("R6", "gate resumes", gate_on, 1'b1);
    // R7: clear held low, new fault latches
    step(1, 0, 0, 1, 1, 1, 120, "R7");
    chk("R7", "new fault blocks gate while clear held", gate_on, 1'b0);
    step(1, 0, 0, 0, 1, 1, FD + 50, "R7");
    chk("R7", "fault stays latched under held clear", fault_n, 1'b0);
    step(1, 0, 1, 0, 1, 1, 3, "R7");
    step(1, 0, 0, 0, 1, 1, CL + 2, "R6");
    chk("R6", "second clear releases", fault_n, 1'b1);
    step(1, 0, 1, 0, 1, 1, 5, "R6");
    // R10: supply loss clears trip and filters
    step(1, 0, 1, 1, 1, 1, 120, "R4");
    step(1, 0, 1, 0, 1, 1, FD + 5, "R5");
    chk("R5", "tripped before supply loss", fault_n, 1'b0);
    step(1, 0, 1, 0, 0, 1, 1, "R10");
    chk("R8", "ready low on input supply", ready, 1'b0);
    step(1, 0, 1, 0, 0, 1, 2, "R10");
    chk("R10", "fault released by supply loss", fault_n, 1'b1);
    step(1, 0, 1, 0, 1, 1, 4, "R10");
    chk("R10", "filters restarted from idle", gate_on, 1'b0);
    step(1, 0, 1, 0, 1, 1, 1, "R10");
    chk("R10", "gate on after full filter", gate_on, 1'b1);

    // mixed patterns compared against the model every cycle
    lf = 16'hACE1; rp = 1; rn = 0; rc = 1; ri = 1; ro = 1;
    for (int k = 0; k < 6000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[3:0] == 4'd0) rp = ~rp;
      if (lf[7:3] == 5'd0) rn = ~rn;
      if (lf[13:8] == 6'd0) rc = ~rc;
      if (lf[15:5] == 11'd3) ri = ~ri;
      if (lf[15:6] == 10'd7) ro = ~ro;
      if (!ri && lf[2:0] == 3'd1) ri = 1;
      if (!ro && lf[2:0] == 3'd2) ro = 1;
      step(rp, rn, rc, lf[9] | lf[11], ri, ro, 1, "R4");
    end
    finish_run();
  end
endmodule